// File: doc/BRIEF.md
# Two-Wire Register Slave with Transfer-Register Snapshot

This block is a two-wire (I2C-style) target that opens a ten-byte space of timekeeping and control values to an external bus master. SCL and SDA pass through a synchronizer on a fast system clock. The synchronized lines feed an edge detector that finds SCL edges and START/STOP conditions. A bit-level state machine then matches the slave address, loads and advances a word pointer, acknowledges received bytes, and shifts read data out MSB first. The block pulls SDA low through `sda_oe` and never drives it high.

The master never reaches the running counters directly. A bank of transfer registers is loaded from the parallel `live_in` port when a matching address byte is accepted. All bus reads and writes then work on this bank. When a STOP closes an access in which at least one data byte was written, the whole bank is presented on `commit_data` with a one-cycle `commit_stb`, and the counter logic loads it. A carry in the counters therefore never shows up half-updated in the middle of a multi-byte access.

The system clock must run at least eight times faster than SCL.

Top module: `twowire_snap_slave`

## Requirements
- R1: The block acknowledges only the address byte 8'hD0 (write) or 8'hD1 (read), which is 7-bit address 7'h68 with the direction in bit 0 (1 = read). After any other address byte it does not acknowledge and leaves SDA released until the next START.
- R2: During the ninth SCL clock after each address byte, pointer byte or write-data byte that it accepts, the block pulls SDA low. It releases SDA at the following SCL fall.
- R3: In a write access, the first byte after the address loads the word pointer. A value of 10 or more loads 0. The pointer keeps its value across STOP and START.
- R4: Each following write byte is stored into the transfer register at the pointer and is acknowledged. The pointer then advances, wrapping from 9 to 0.
- R5: In a read access, the block sends the transfer register at the pointer, MSB first, each bit held on SDA for a whole SCL high phase. After each byte the pointer advances, wrapping from 9 to 0. While the master acknowledges, the block continues with the next byte.
- R6: The transfer registers are loaded from `live_in` (byte i at bits 8i+7..8i) when a matching address byte is accepted, unless written bytes are still waiting to be committed. A change on `live_in` after that point is not seen until the next access.
- R7: A STOP that ends an access in which at least one data byte was written raises `commit_stb` for exactly one cycle, with all ten transfer registers on `commit_data`. A STOP after a read, after a pointer-only write, or after an address that was not matched gives no strobe.
- R8: A master NACK after a read byte ends the read. The block keeps SDA released through any further clocks until the next START.
- R9: After reset, `sda_oe` and `commit_stb` are low and the word pointer is 0.
- R10: The block changes `sda_oe` only while the synchronized SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| live_in | input | 80 | Current counter bytes, byte i at bits 8i+7..8i |
| commit_stb | output | 1 | One-cycle strobe telling the counters to load commit_data |
| commit_data | output | 80 | Transfer-register bank, same byte layout as live_in |

## Verification
A wrong pointer value shows up at the ports in the very next read byte: the master receives a value from the wrong register, or a written value lands in the wrong byte of `commit_data` at the following STOP. A bad snapshot decision shows when a value poked onto `live_in` in the middle of a read appears in the same access. It also shows when a written but uncommitted byte is replaced by the counter value after a repeated START. Errors in the acknowledge or release logic show within one SCL period, as a missing ACK, a missing release on an unmatched address, or SDA still held after a NACK.

// File: rtl/tws_pkg.sv
package tws_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_IGNORE,
        ST_ACK_ADDR,
        ST_WORD,
        ST_ACK_WR,
        ST_WDATA,
        ST_SEND,
        ST_MACK
    } tws_state_e;

endpackage

// File: rtl/tws_sync.sv
module tws_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] stg_q [STAGES];
    logic [WIDTH-1:0] stg_d [STAGES];

    always_comb begin
        stg_d[0] = async_in;
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                stg_q[i] <= '1;
            end
        end else begin
            for (int i = 0; i < STAGES; i++) begin
                stg_q[i] <= stg_d[i];
            end
        end
    end

    assign sync_out = stg_q[STAGES-1];

endmodule

// File: rtl/tws_edge.sv
module tws_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_evt,
    output logic stop_evt
);

    logic scl_p_q, sda_p_q;
    logic scl_p_d, sda_p_d;

    always_comb begin
        scl_p_d = scl_s;
        sda_p_d = sda_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_p_q <= 1'b1;
            sda_p_q <= 1'b1;
        end else begin
            scl_p_q <= scl_p_d;
            sda_p_q <= sda_p_d;
        end
    end

    assign scl_rise  = scl_s & ~scl_p_q;
    assign scl_fall  = ~scl_s & scl_p_q;
    assign start_evt = scl_s & scl_p_q & sda_p_q & ~sda_s;
    assign stop_evt  = scl_s & scl_p_q & ~sda_p_q & sda_s;

endmodule

// File: rtl/tws_shadow.sv
module tws_shadow #(
    parameter int NREG = 10,
    parameter int PW   = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_en,
    input  logic [NREG*8-1:0] live_flat,
    input  logic              wr_en,
    input  logic [PW-1:0]     wr_idx,
    input  logic [7:0]        wr_byte,
    input  logic [PW-1:0]     rd_idx,
    output logic [7:0]        rd_byte,
    output logic [NREG*8-1:0] regs_flat
);

    logic [7:0] mem_q [NREG];
    logic [7:0] mem_d [NREG];

    always_comb begin
        for (int i = 0; i < NREG; i++) begin
            mem_d[i] = mem_q[i];
            if (wr_en && (32'(wr_idx) == i)) begin
                mem_d[i] = wr_byte;
            end else if (cap_en) begin
                mem_d[i] = live_flat[i*8 +: 8];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) begin
                mem_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < NREG; i++) begin
                mem_q[i] <= mem_d[i];
            end
        end
    end

    always_comb begin
        rd_byte = '0;
        for (int i = 0; i < NREG; i++) begin
            if (32'(rd_idx) == i) begin
                rd_byte = mem_q[i];
            end
        end
    end

    generate
        for (genvar g = 0; g < NREG; g++) begin : g_flat
            assign regs_flat[g*8 +: 8] = mem_q[g];
        end
    endgenerate

endmodule

// File: rtl/twowire_snap_slave.sv
module twowire_snap_slave #(
    parameter logic [6:0] SLAVE_ADDR  = 7'h68,
    parameter int         NREG        = 10,
    parameter int         SYNC_STAGES = 2,
    localparam int        PW          = $clog2(NREG),
    localparam int        DW          = NREG * 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_in,
    input  logic          sda_in,
    output logic          sda_oe,
    input  logic [DW-1:0] live_in,
    output logic          commit_stb,
    output logic [DW-1:0] commit_data
);
    import tws_pkg::*;

    typedef struct packed {
        tws_state_e    st;
        logic [3:0]    cnt;
        logic [7:0]    sh;
        logic [7:0]    tx;
        logic          rw;
        logic          nack;
        logic          oe;
        logic [PW-1:0] ptr;
        logic          dirty;
        logic          commit;
    } ctl_t;

    logic [1:0] sync_v;
    logic       scl_s, sda_s;
    logic       scl_rise, scl_fall, start_evt, stop_evt;
    logic       cap_en, wr_en;
    logic [7:0] rd_byte;
    logic [PW-1:0] ptr_cur;

    ctl_t st_q, st_d;

    tws_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({scl_in, sda_in}),
        .sync_out (sync_v)
    );
    assign scl_s = sync_v[1];
    assign sda_s = sync_v[0];

    tws_edge u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_evt (start_evt),
        .stop_evt  (stop_evt)
    );

    tws_shadow #(.NREG(NREG), .PW(PW)) u_shadow (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap_en    (cap_en),
        .live_flat (live_in),
        .wr_en     (wr_en),
        .wr_idx    (st_q.ptr),
        .wr_byte   (st_q.sh),
        .rd_idx    (st_q.ptr),
        .rd_byte   (rd_byte),
        .regs_flat (commit_data)
    );

    function automatic logic [PW-1:0] ptr_next(input logic [PW-1:0] p);
        return (p == PW'(NREG - 1)) ? '0 : p + PW'(1);
    endfunction

    always_comb begin
        st_d        = st_q;
        st_d.commit = 1'b0;
        cap_en      = 1'b0;
        wr_en       = 1'b0;

        if (start_evt) begin
            st_d.st  = ST_ADDR;
            st_d.cnt = '0;
            st_d.oe  = 1'b0;
        end else if (stop_evt) begin
            st_d.st = ST_IDLE;
            st_d.oe = 1'b0;
            if (st_q.dirty) begin
                st_d.commit = 1'b1;
                st_d.dirty  = 1'b0;
            end
        end else begin
            case (st_q.st)
                ST_ADDR, ST_WORD, ST_WDATA: begin
                    if (scl_rise) begin
                        st_d.sh  = {st_q.sh[6:0], sda_s};
                        st_d.cnt = st_q.cnt + 4'd1;
                    end else if (scl_fall && st_q.cnt == 4'd8) begin
                        st_d.cnt = '0;
                        st_d.oe  = 1'b1;
                        if (st_q.st == ST_ADDR) begin
                            if (st_q.sh[7:1] == SLAVE_ADDR) begin
                                st_d.rw = st_q.sh[0];
                                st_d.st = ST_ACK_ADDR;
                                cap_en  = ~st_q.dirty;
                            end else begin
                                st_d.oe = 1'b0;
                                st_d.st = ST_IGNORE;
                            end
                        end else if (st_q.st == ST_WORD) begin
                            st_d.ptr = (st_q.sh < 8'(NREG)) ? st_q.sh[PW-1:0] : '0;
                            st_d.st  = ST_ACK_WR;
                        end else begin
                            wr_en      = 1'b1;
                            st_d.dirty = 1'b1;
                            st_d.ptr   = ptr_next(st_q.ptr);
                            st_d.st    = ST_ACK_WR;
                        end
                    end
                end
                ST_ACK_ADDR: begin
                    if (scl_fall) begin
                        if (st_q.rw) begin
                            st_d.tx  = rd_byte;
                            st_d.ptr = ptr_next(st_q.ptr);
                            st_d.oe  = ~rd_byte[7];
                            st_d.st  = ST_SEND;
                        end else begin
                            st_d.oe = 1'b0;
                            st_d.st = ST_WORD;
                        end
                    end
                end
                ST_ACK_WR: begin
                    if (scl_fall) begin
                        st_d.oe = 1'b0;
                        st_d.st = ST_WDATA;
                    end
                end
                ST_SEND: begin
                    if (scl_rise) begin
                        st_d.cnt = st_q.cnt + 4'd1;
                    end else if (scl_fall) begin
                        if (st_q.cnt == 4'd8) begin
                            st_d.cnt = '0;
                            st_d.oe  = 1'b0;
                            st_d.st  = ST_MACK;
                        end else begin
                            st_d.tx = {st_q.tx[6:0], 1'b0};
                            st_d.oe = ~st_q.tx[6];
                        end
                    end
                end
                ST_MACK: begin
                    if (scl_rise) begin
                        st_d.nack = sda_s;
                    end else if (scl_fall) begin
                        if (st_q.nack) begin
                            st_d.oe = 1'b0;
                            st_d.st = ST_IDLE;
                        end else begin
                            st_d.tx  = rd_byte;
                            st_d.ptr = ptr_next(st_q.ptr);
                            st_d.oe  = ~rd_byte[7];
                            st_d.st  = ST_SEND;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{st: ST_IDLE, cnt: '0, sh: '0, tx: '0, rw: 1'b0, nack: 1'b0,
                      oe: 1'b0, ptr: '0, dirty: 1'b0, commit: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign sda_oe     = st_q.oe;
    assign commit_stb = st_q.commit;
    assign ptr_cur    = st_q.ptr;

endmodule

// File: rtl/tws_checker.sv
module tws_checker #(
    parameter int NREG = 10,
    parameter int PW   = $clog2(NREG)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          scl_s,
    input logic          start_evt,
    input logic          stop_evt,
    input logic          sda_oe,
    input logic          commit_stb,
    input logic [PW-1:0] ptr
);

    // R10
    oe_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_s);

    // R7
    commit_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit_stb |=> !commit_stb);

    // R7
    commit_on_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit_stb |-> $past(stop_evt));

    // R4
    ptr_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        32'(ptr) < NREG);

    // R8
    start_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_evt |=> !sda_oe);

endmodule

bind twowire_snap_slave tws_checker #(.NREG(NREG), .PW(PW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_s      (scl_s),
    .start_evt  (start_evt),
    .stop_evt   (stop_evt),
    .sda_oe     (sda_oe),
    .commit_stb (commit_stb),
    .ptr        (ptr_cur)
);

// File: tb/tb_twowire_snap_slave.sv
module tb_twowire_snap_slave;

    localparam int CLK_PERIOD = 10;
    localparam int Q          = 8;
    localparam int NREG       = 10;
    localparam int DW         = NREG * 8;
    localparam logic [11:0] VEC [0:5] = '{12'h0A5, 12'h35A, 12'h9FF, 12'h500, 12'h13C, 12'h7C3};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic sda_oe, commit_stb;
    logic [DW-1:0] live, commit_data;
    logic sda_bus;

    logic       poke_req = 1'b0;
    int         poke_idx = 0;
    logic [7:0] poke_val = '0;

    int n_chk = 0;
    int n_fail = 0;
    int commit_cnt = 0;
    logic done = 1'b0;
    logic [7:0] exp_reg [NREG];

    always #(CLK_PERIOD/2) clk = ~clk;

    assign sda_bus = m_sda & ~sda_oe;

    twowire_snap_slave dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_in      (m_scl),
        .sda_in      (sda_bus),
        .sda_oe      (sda_oe),
        .live_in     (live),
        .commit_stb  (commit_stb),
        .commit_data (commit_data)
    );

    // counter model: loads the committed bank, accepts bench pokes
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) live[i*8 +: 8] <= 8'h40 + 8'(i);
        end else if (commit_stb) begin
            commit_cnt <= commit_cnt + 1;
            live <= commit_data;
        end else if (poke_req) begin
            live[poke_idx*8 +: 8] <= poke_val;
        end
    end

    task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic hq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic clk_bit(input logic b, output logic s);
        m_sda = b; hq();
        m_scl = 1'b1; hq();
        s = sda_bus; hq();
        m_scl = 1'b0; hq();
    endtask

    task automatic bus_start();
        m_sda = 1'b1; hq();
        m_scl = 1'b1; hq();
        m_sda = 1'b0; hq();
        m_scl = 1'b0; hq();
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; hq();
        m_scl = 1'b1; hq();
        m_sda = 1'b1; hq();
        hq();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
        clk_bit(1'b1, s);
        ack = ~s;
    endtask

    task automatic recv_byte(input logic mack, output logic [7:0] d);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            clk_bit(1'b1, s);
            d[i] = s;
        end
        clk_bit(~mack, s);
        m_sda = 1'b1;
    endtask

    task automatic set_ptr(input logic [7:0] p, input string tag);
        logic a;
        bus_start();
        send_byte(8'hD0, a); check(a, {"R1 write address ack ", tag}, 32'(a), 1);
        send_byte(p, a);     check(a, {"R2 pointer ack ", tag}, 32'(a), 1);
    endtask

    task automatic start_read(input string tag);
        logic a;
        bus_start();
        send_byte(8'hD1, a); check(a, {"R1 read address ack ", tag}, 32'(a), 1);
    endtask

    task automatic send_data(input logic [7:0] d, input string tag);
        logic a;
        send_byte(d, a); check(a, {"R2 R4 data ack ", tag}, 32'(a), 1);
    endtask

    initial begin
        logic [7:0] d;
        logic a;
        int c0;
        for (int i = 0; i < NREG; i++) exp_reg[i] = 8'h40 + 8'(i);
        repeat (5) @(negedge clk);
        check(sda_oe == 1'b0, "R9 sda_oe after reset", 32'(sda_oe), 0);
        check(commit_stb == 1'b0, "R9 commit_stb after reset", 32'(commit_stb), 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R9: pointer 0 after reset, read at current pointer
        start_read("reset");
        recv_byte(1'b0, d);
        check(d == exp_reg[0], "R9 R5 first read at pointer 0", 32'(d), 32'(exp_reg[0]));
        bus_stop();

        // vector table: single-byte write, commit, read back
        for (int v = 0; v < 6; v++) begin
            int r;
            logic [7:0] val;
            r = int'(VEC[v][11:8]);
            val = VEC[v][7:0];
            c0 = commit_cnt;
            set_ptr(8'(r), "vec");
            send_data(val, "vec");
            bus_stop();
            exp_reg[r] = val;
            check(commit_cnt == c0 + 1, "R7 commit count after write", 32'(commit_cnt), 32'(c0 + 1));
            check(live[r*8 +: 8] == val, "R4 R7 committed byte", 32'(live[r*8 +: 8]), 32'(val));
            set_ptr(8'(r), "vec read");
            start_read("vec");
            recv_byte(1'b0, d);
            bus_stop();
            check(d == val, "R5 read back", 32'(d), 32'(val));
        end

        // R4: multi-byte write wraps 9 -> 0
        set_ptr(8'd8, "wrap");
        send_data(8'h11, "wrap");
        send_data(8'h22, "wrap");
        send_data(8'h33, "wrap");
        bus_stop();
        exp_reg[8] = 8'h11; exp_reg[9] = 8'h22; exp_reg[0] = 8'h33;
        check(live[8*8 +: 8] == 8'h11, "R4 wrap byte 8", 32'(live[8*8 +: 8]), 32'h11);
        check(live[9*8 +: 8] == 8'h22, "R4 wrap byte 9", 32'(live[9*8 +: 8]), 32'h22);
        check(live[7:0] == 8'h33, "R4 wrap byte 0", 32'(live[7:0]), 32'h33);

        // R5, R8: sequential read wraps, NACK releases bus
        set_ptr(8'd9, "rwrap");
        start_read("rwrap");
        recv_byte(1'b1, d);
        check(d == 8'h22, "R5 read byte 9", 32'(d), 32'h22);
        recv_byte(1'b0, d);
        check(d == 8'h33, "R5 read wraps to byte 0", 32'(d), 32'h33);
        recv_byte(1'b0, d);
        check(d == 8'hFF, "R8 SDA released after NACK", 32'(d), 32'hFF);
        bus_stop();

        // R1: foreign address ignored
        c0 = commit_cnt;
        bus_start();
        send_byte(8'hA0, a);
        check(a == 1'b0, "R1 no ack on foreign address", 32'(a), 0);
        recv_byte(1'b0, d);
        check(d == 8'hFF, "R1 SDA released after foreign address", 32'(d), 32'hFF);
        bus_stop();
        check(commit_cnt == c0, "R7 no commit after foreign address", 32'(commit_cnt), 32'(c0));

        // R3, R7: pointer-only write keeps pointer, no commit
        set_ptr(8'd2, "ptr only");
        bus_stop();
        check(commit_cnt == c0, "R7 no commit after pointer-only write", 32'(commit_cnt), 32'(c0));
        start_read("ptr kept");
        recv_byte(1'b0, d);
        bus_stop();
        check(d == exp_reg[2], "R3 pointer kept across STOP", 32'(d), 32'(exp_reg[2]));
        check(commit_cnt == c0, "R7 no commit after read", 32'(commit_cnt), 32'(c0));

        // R3: out-of-range pointer loads 0
        set_ptr(8'h0C, "range");
        send_data(8'h77, "range");
        bus_stop();
        exp_reg[0] = 8'h77;
        check(live[7:0] == 8'h77, "R3 out-of-range pointer writes byte 0", 32'(live[7:0]), 32'h77);

        // R6: live change during read not visible
        set_ptr(8'd2, "snap");
        start_read("snap");
        recv_byte(1'b1, d);
        check(d == exp_reg[2], "R6 snapshot byte 2", 32'(d), 32'(exp_reg[2]));
        poke_idx = 3; poke_val = 8'hEE; poke_req = 1'b1;
        @(negedge clk); poke_req = 1'b0;
        recv_byte(1'b0, d);
        bus_stop();
        check(d == exp_reg[3], "R6 mid-read live change hidden", 32'(d), 32'(exp_reg[3]));
        exp_reg[3] = 8'hEE;
        set_ptr(8'd3, "snap new");
        start_read("snap new");
        recv_byte(1'b0, d);
        bus_stop();
        check(d == 8'hEE, "R6 next access captures new value", 32'(d), 32'hEE);

        // R6, R7: pending write kept across repeated START
        c0 = commit_cnt;
        set_ptr(8'd4, "pend");
        send_data(8'h99, "pend");
        set_ptr(8'd4, "pend again");
        start_read("pend");
        recv_byte(1'b0, d);
        check(d == 8'h99, "R6 uncommitted write not overwritten", 32'(d), 32'h99);
        check(commit_cnt == c0, "R7 no commit before STOP", 32'(commit_cnt), 32'(c0));
        bus_stop();
        check(commit_cnt == c0 + 1, "R7 commit after STOP", 32'(commit_cnt), 32'(c0 + 1));
        check(live[4*8 +: 8] == 8'h99, "R7 committed pending byte", 32'(live[4*8 +: 8]), 32'h99);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule